// File: doc/BRIEF.md
# Selectable Delay-Line Memory Controller

This block owns the storage of a one-bit delta-modulated audio delay line. Each accepted input bit is written into a circular bit memory at a write pointer. A read pointer trails the write pointer by a whole number of fixed memory segments. The memory is split into `NSTEPS` equal segments of `STEP` bits. A 3-bit delay code selects a lag of (code+1) segments, so code 5 uses the whole span. The sample strobe runs at one of two rates. The slow rate is half the fast one, so the same code gives twice the delay time in slow mode. With `STEP`=2048 the memory holds 12288 bits, and the delay steps come out as 10 ms steps in fast mode and 20 ms steps in slow mode. The default parameters scale the memory down so that it stays small at elaboration.

The delay code and the rate select are taken up only while the system mute is active. When the system mute rises, a clear engine writes every address with its own address parity. This leaves an alternating 0/1 idle stream, which stands for silence in delta modulation. The block reports itself as muted until that walk is complete and the mute request has been released. While muted, the output carries an alternating idle pattern. The input side also has its own mute, which puts the idle pattern into the buffer in place of the incoming data. Codes 6 and 7 are not legal. They act as code 5 and raise an error flag.

The block sets the pace of both streams, so its input is a pull interface. On each sample strobe that falls outside mute, `in_ready` is high for exactly one clock. A bit transfers when `in_valid` is also high. If the producer has no valid bit at that cycle, the idle bit for that address is stored, and the producer must keep its bit for the next strobe. The output has no back-pressure. `out_valid` is high for one clock per strobe, and the consumer must take `out_bit` in that cycle.

Top module: `dlc_delay_line`

## Requirements
- R1: After reset the block reports `muted`=1, `in_ready`=0, `out_valid`=0 and `cfg_err`=0. `muted` falls on its own after about `DEPTH` (=`NSTEPS`*`STEP`) cycles, once the clear walk has finished.
- R2: Outside mute, the output bit of the k-th strobe after mute exit equals the bit stored at strobe k-(code+1)*`STEP`. Numbering starts at 0, and this holds across pointer wrap.
- R3: A strobe (`in_ready` pulse) comes every `FAST_DIV` cycles when the latched rate select is 0, and every 2*`FAST_DIV` cycles when it is 1.
- R4: A delay code above 5 (binary 110 or 111) taken during mute acts as code 5 and sets `cfg_err`=1. Codes 0 to 5 set `cfg_err`=0.
- R5: Changes to `delay_code` or `slow_mode` while not muted have no effect on the delay, the rate or `cfg_err` until the next mute.
- R6: After each mute exit, any output strobe k that reaches back before the first stored bit (k < delay) gives the value k mod 2, so the sequence is 0,1,0,1,...
- R7: A rising `sys_mute` makes `muted` high from the next cycle for exactly `DEPTH` cycles when the request is short. `muted` stays high for as long as `sys_mute` is held, and `in_ready` stays 0 while `muted` is high.
- R8: While muted, `out_valid` keeps pulsing at the strobe rate and consecutive `out_bit` values alternate.
- R9: While `in_mute`=1, the stored bit at write index j is j mod 2 whatever the input carries.
- R10: `in_ready` is never high two cycles in a row. A strobe with `in_valid`=0 stores j mod 2 at write index j.
- R11: `out_valid` is high in the cycle right after each cycle in which `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_code | input | 3 | Delay segment count minus one; sampled only while muted |
| slow_mode | input | 1 | 1 selects half-rate strobe; sampled only while muted |
| sys_mute | input | 1 | System mute request; a rising edge starts the clear walk |
| in_mute | input | 1 | Store the idle pattern in place of input data |
| in_valid | input | 1 | Producer has a bit on in_bit |
| in_bit | input | 1 | Input delta-modulated bit |
| in_ready | output | 1 | Block takes a bit this cycle |
| out_valid | output | 1 | out_bit is valid this cycle |
| out_bit | output | 1 | Delayed or idle output bit |
| muted | output | 1 | Mute request or clear walk active |
| cfg_err | output | 1 | Latched delay code was illegal |

## Verification
A wrong read offset, or a wrong wrap at the buffer end, shows up as a miscompare on `out_bit`. This happens in the first strobe that reaches past the idle region, which is exactly `delay` strobes after mute exit. A clear walk that skips any address shows up earlier, as a break in the 0,1 idle sequence within the first `delay` outputs. A latched configuration that drifts outside mute shows up at the next strobe, either as a changed strobe spacing or as a flip of `cfg_err`. A mute-length error shows up in the first mute, through the count of `muted` cycles.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] dcode_t;

  // Clamp a raw delay code to the highest legal segment index.
  function automatic dcode_t clamp_code(dcode_t raw, dcode_t top);
    return (raw > top) ? top : raw;
  endfunction
endpackage

// File: rtl/dlc_rate_gen.sv
module dlc_rate_gen #(
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick
);
  localparam int CW = $clog2(2*FAST_DIV + 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(2*FAST_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = slow ? LIM_SLOW : LIM_FAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dlc_clear_engine.sv
module dlc_clear_engine #(
  parameter int DEPTH = 1536,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          wbit
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // Reset starts a walk as well, so the memory never holds unknowns.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) begin
        busy <= 1'b0;
        addr <= '0;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  // Address parity gives the alternating idle pattern.
  assign wbit = addr[0];
endmodule

// File: rtl/dlc_rd_addr.sv
module dlc_rd_addr #(
  parameter int DEPTH = 1536,
  parameter int STEP  = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]  wr_ptr,
  input  dlc_pkg::dcode_t code,
  output logic [AW-1:0]  rd_ptr
);
  logic [AW:0] lag;
  logic [AW:0] wr_ext;
  logic [AW:0] rd_full;

  assign lag    = (AW+1)'((32'(code) + 32'd1) * 32'(STEP));
  assign wr_ext = {1'b0, wr_ptr};
  assign rd_full = (wr_ext >= lag) ? (wr_ext - lag)
                                   : (wr_ext + (AW+1)'(DEPTH) - lag);
  assign rd_ptr = rd_full[AW-1:0];
endmodule

// File: rtl/dlc_delay_line.sv
module dlc_delay_line #(
  parameter int STEP     = 256,
  parameter int NSTEPS   = 6,
  parameter int FAST_DIV = 4,
  localparam int DEPTH = STEP * NSTEPS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] delay_code,
  input  logic       slow_mode,
  input  logic       sys_mute,
  input  logic       in_mute,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit,
  output logic       muted,
  output logic       cfg_err
);
  import dlc_pkg::*;

  localparam dcode_t        CODE_TOP = dcode_t'(NSTEPS - 1);
  localparam logic [AW-1:0] WR_LAST  = AW'(DEPTH - 1);

  logic          mute_r;
  logic          clr_start;
  logic          clr_busy;
  logic [AW-1:0] clr_addr;
  logic          clr_bit;
  dcode_t        cfg_code;
  logic          cfg_slow;
  logic          tick;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          idle_ph;
  logic          wdata;
  logic          mem [DEPTH];

  assign clr_start = sys_mute & ~mute_r;
  assign muted     = mute_r | clr_busy;
  assign in_ready  = tick & ~muted;
  assign wdata     = (in_valid & ~in_mute) ? in_bit : wr_ptr[0];

  dlc_clear_engine #(.DEPTH(DEPTH)) u_clr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(clr_start),
    .busy (clr_busy),
    .addr (clr_addr),
    .wbit (clr_bit)
  );

  dlc_rate_gen #(.FAST_DIV(FAST_DIV)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .slow (cfg_slow),
    .tick (tick)
  );

  dlc_rd_addr #(.DEPTH(DEPTH), .STEP(STEP)) u_rd (
    .wr_ptr(wr_ptr),
    .code  (cfg_code),
    .rd_ptr(rd_ptr)
  );

  // Configuration is taken up only while muted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mute_r   <= 1'b0;
      cfg_code <= '0;
      cfg_slow <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      mute_r <= sys_mute;
      if (muted) begin
        cfg_code <= clamp_code(delay_code, CODE_TOP);
        cfg_slow <= slow_mode;
        cfg_err  <= (delay_code > CODE_TOP);
      end
    end
  end

  // Write pointer and output stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      idle_ph   <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= tick;
      if (muted) begin
        wr_ptr <= '0;
        if (tick) begin
          out_bit <= idle_ph;
          idle_ph <= ~idle_ph;
        end
      end else if (tick) begin
        out_bit <= mem[rd_ptr];
        wr_ptr  <= (wr_ptr == WR_LAST) ? '0 : wr_ptr + 1'b1;
      end
    end
  end

  // Bit memory: clear walk has priority, stream writes otherwise.
  always_ff @(posedge clk) begin
    if (clr_busy) begin
      mem[clr_addr] <= clr_bit;
    end else if (tick && !muted) begin
      mem[wr_ptr] <= wdata;
    end
  end
endmodule

// File: rtl/dlc_delay_line_chk.sv
module dlc_delay_line_chk #(
  parameter int DEPTH    = 1536,
  parameter int FAST_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] delay_code,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_bit,
  input logic       muted,
  input logic       cfg_err
);
  logic [31:0] mcnt;
  logic        muted_d;
  logic        idle_seen;
  logic        idle_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt      <= '0;
      muted_d   <= 1'b0;
      idle_seen <= 1'b0;
      idle_last <= 1'b0;
    end else begin
      mcnt    <= muted ? mcnt + 1 : '0;
      muted_d <= muted;
      if (out_valid) begin
        idle_seen <= muted_d;
        idle_last <= out_bit;
      end
    end
  end

  assert_ready_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> !in_ready);

  assert_mute_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (muted_d && !muted) |-> (mcnt >= 32'(DEPTH)));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> out_valid);

  assert_err_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && delay_code > 3'd5) |=> cfg_err);

  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!muted && !muted_d) |-> $stable(cfg_err));

  assert_idle_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && muted_d && idle_seen) |-> (out_bit != idle_last));
endmodule

bind dlc_delay_line dlc_delay_line_chk #(.DEPTH(DEPTH), .FAST_DIV(FAST_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .delay_code(delay_code),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .muted     (muted),
  .cfg_err   (cfg_err)
);

// File: tb/dlc_delay_line_tb.sv
module dlc_delay_line_tb;
  localparam int STEP     = 256;
  localparam int NSTEPS   = 6;
  localparam int FAST_DIV = 4;
  localparam int DEPTH    = STEP * NSTEPS;
  localparam int EXTRA    = 300;
  localparam int NVEC     = 7;
  // Fields: [5:3] delay code, [2] slow, [1] input mute, [0] producer gaps
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b0, 1'b0, 1'b0},
    {3'd7, 1'b0, 1'b0, 1'b1},
    {3'd1, 1'b0, 1'b1, 1'b0},
    {3'd6, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b0, 1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] delay_code;
  logic       slow_mode;
  logic       sys_mute;
  logic       in_mute;
  logic       in_valid;
  logic       in_bit;
  logic       in_ready;
  logic       out_valid;
  logic       out_bit;
  logic       muted;
  logic       cfg_err;

  int          nchk = 0;
  int          nfail = 0;
  bit          hist [4096];
  logic [15:0] lfsr = 16'hACE1;

  dlc_delay_line #(.STEP(STEP), .NSTEPS(NSTEPS), .FAST_DIV(FAST_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .delay_code(delay_code), .slow_mode(slow_mode),
    .sys_mute(sys_mute), .in_mute(in_mute), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .muted(muted), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  // Mute request held for 'hold' cycles; checks R7 and R8.
  task automatic mute_cycle(input int hold);
    int  mcnt = 0;
    bit  seen = 0;
    bit  last = 0;
    bit  first = 1;
    @(negedge clk);
    sys_mute = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (muted) mcnt++;
      if (in_ready) check(1'b0, "R7 in_ready while muted", 1, 0);
      if (out_valid && !first) begin
        if (seen) check(out_bit != last, "R8 idle alternation", out_bit, !last);
        seen = 1; last = out_bit;
      end
      first = 0;
    end
    sys_mute = 1'b0;
    if (hold > DEPTH) check(mcnt == hold, "R7 mute held with request", mcnt, hold);
    while (muted) begin
      @(negedge clk);
      if (muted) begin
        mcnt++;
        if (in_ready) check(1'b0, "R7 in_ready while muted", 1, 0);
        if (out_valid) begin
          if (seen) check(out_bit != last, "R8 idle alternation", out_bit, !last);
          seen = 1; last = out_bit;
        end
      end
    end
    if (hold < DEPTH) check(mcnt == DEPTH, "R7 mute length", mcnt, DEPTH);
    else check(mcnt <= hold + 2, "R7 mute release", mcnt, hold + 1);
  endtask

  task automatic run_cfg(input logic [5:0] v);
    logic [2:0] code = v[5:3];
    bit slow  = v[2];
    bit imute = v[1];
    bit gaps  = v[0];
    int eff, dly, k_in, k_out, cyc, last_cyc;
    bit pending, started;
    delay_code = code;
    slow_mode  = slow;
    in_mute    = imute;
    mute_cycle(20);
    check(cfg_err == (code > 3'd5), "R4 cfg_err", cfg_err, code > 3'd5);
    eff = (code > 3'd5) ? 5 : int'(code);
    dly = (eff + 1) * STEP;
    // R5: perturb configuration outside mute
    delay_code = code ^ 3'b010;
    slow_mode  = ~slow;
    k_in = 0; k_out = 0; cyc = 0; last_cyc = 0; pending = 0; started = 0;
    while (k_out < dly + EXTRA) begin
      @(negedge clk);
      cyc++;
      if (started && (pending || out_valid))
        check(out_valid == pending, "R11 out_valid timing", out_valid, pending);
      if (pending && out_valid) begin
        bit exp;
        exp = (k_out >= dly) ? hist[k_out - dly] : bit'(k_out % 2);
        if (k_out >= dly)
          check(out_bit == exp, imute ? "R9 input mute" : (gaps ? "R10 gap fill / R2" : "R2 delayed bit"), out_bit, exp);
        else
          check(out_bit == exp, "R6 idle before data", out_bit, exp);
        k_out++;
      end
      pending = 0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_bit   = lfsr[0];
      in_valid = gaps ? (lfsr[4] | lfsr[7]) : 1'b1;
      if (in_ready) begin
        started = 1;
        hist[k_in] = (in_valid && !imute) ? in_bit : bit'(k_in % 2);
        k_in++;
        pending = 1;
        if (k_in == 3)
          check(cyc - last_cyc == (slow ? 2 : 1) * FAST_DIV, "R3 strobe spacing",
                cyc - last_cyc, (slow ? 2 : 1) * FAST_DIV);
        last_cyc = cyc;
      end
    end
    check(cfg_err == (code > 3'd5), "R5 cfg_err frozen", cfg_err, code > 3'd5);
  endtask

  initial begin
    int rcnt;
    rst_n = 1'b0; delay_code = 3'd0; slow_mode = 1'b0; sys_mute = 1'b0;
    in_mute = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(muted == 1'b1, "R1 muted after reset", muted, 1);
    check(in_ready == 1'b0, "R1 in_ready after reset", in_ready, 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(cfg_err == 1'b0, "R1 cfg_err after reset", cfg_err, 0);
    rcnt = 0;
    while (muted && rcnt < 4 * DEPTH) begin
      @(negedge clk);
      if (muted) rcnt++;
    end
    check(rcnt >= DEPTH - 1 && rcnt <= DEPTH, "R1 reset clear length", rcnt, DEPTH);

    for (int i = 0; i < NVEC; i++) run_cfg(VEC[i]);

    // Corner: mute request held longer than the walk (R7)
    delay_code = 3'd3;
    slow_mode  = 1'b0;
    mute_cycle(DEPTH + 200);
    check(muted == 1'b0, "R7 unmuted after release", muted, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule